// File: doc/BRIEF.md
# Microcoded Datapath ALU and Shifter

This block is the combinational arithmetic stage of a microcoded datapath. It takes a left operand from the holding register and a right operand from the operand bus. A six-bit function field and a two-bit shift field, both taken from the current microinstruction, control it. The shifted result is driven back onto the result bus. A sign flag and a zero flag describe the unshifted ALU output. The next-address logic uses these flags for conditional branches.

The block has no separate opcodes for subtraction or constants. Each operand can be gated to zero, the left operand can be inverted after gating, and a carry-in bit feeds the adder. These bits combine to give those results. For example, the function field `110110` (add, left operand off and inverted, right operand on, no carry-in) gives B minus one. A register-transfer step can therefore decrement a pointer or form 0, 1 and -1 without an extra opcode.

Top module: `datapath_alu`

## Requirements
- R1: The function field `fn_ctl` is ordered from bit 5 down to bit 0 as: function select high, function select low, left-operand enable, right-operand enable, invert-left, carry-in. A disabled operand is forced to all zeros before any inversion.
- R2: When invert-left is 1, the gated left operand is bitwise complemented before it reaches the function unit. A disabled and inverted left operand is therefore all ones.
- R3: The function select {bit5,bit4} chooses the operation: 00 gives left AND right, 01 gives left OR right, 10 gives NOT right, and 11 gives left plus right.
- R4: In the add function, the carry-in bit is added into the least significant position. The sum wraps modulo 2^WIDTH. In the three logic functions the carry-in bit has no effect.
- R5: `fn_ctl` = 111100 yields A+B, and `fn_ctl` = 110110 yields B-1.
- R6: `sh_ctl` = 00 passes the ALU output to `c_out` unchanged.
- R7: `sh_ctl` bit 1 alone shifts the ALU output left by LSHIFT (default 8) bits and fills the low bits with zeros.
- R8: `sh_ctl` bit 0 alone shifts the ALU output right by RSHIFT (default 1) bits and replicates the sign bit into the vacated high bits.
- R9: When both `sh_ctl` bits are 1, the left shift is applied first and the arithmetic right shift is applied to its result.
- R10: `neg_flag` equals the most significant bit of the ALU output before shifting.
- R11: `zero_flag` is 1 exactly when every bit of the ALU output before shifting is 0, whatever the shift field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_ctl | input | 6 | Function field: select[1:0], enable-left, enable-right, invert-left, carry-in |
| sh_ctl | input | 2 | Shift field: bit 1 left shift, bit 0 arithmetic right shift |
| a_in | input | WIDTH | Left operand from the holding register |
| b_in | input | WIDTH | Right operand from the operand bus |
| c_out | output | WIDTH | Shifted result for the result bus |
| neg_flag | output | 1 | Sign bit of the unshifted ALU output |
| zero_flag | output | 1 | Unshifted ALU output is all zeros |

## Verification
The bench builds the block with its default parameters: WIDTH of 32, a left shift of 8 and a right shift of 1. These values let the bench reach the carry wrap at 0xFFFFFFFF plus one, the sign bit being pushed in by the left shift, and sign replication on negative values. Directed vectors cover the constant-forming combinations (0, 1, -1, B-1). A pseudo-random stream then sweeps all 64 function codes against all four shift codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  // Bit order follows the microinstruction field, high bit first.
  typedef struct packed {
    alu_fn_e fn;
    logic    en_a;
    logic    en_b;
    logic    inv_a;
    logic    cin;
  } alu_ctl_t;

  typedef struct packed {
    logic left;
    logic right;
  } shift_ctl_t;

endpackage

// File: rtl/operand_gate.sv
module operand_gate #(
  parameter int WIDTH = 32
) (
  input  logic             en,
  input  logic             inv,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  function automatic logic [WIDTH-1:0] gate_fn(input logic e, input logic i,
                                               input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] g;
    g = e ? v : '0;
    return i ? ~g : g;
  endfunction

  assign q = gate_fn(en, inv, d);

  always_comb begin
    if (!en) begin
      assert_disabled_operand_R1: assert (q == (inv ? {WIDTH{1'b1}} : {WIDTH{1'b0}}))
        else $error("disabled operand not constant");
    end
    if (en && inv) begin
      assert_inverted_operand_R2: assert ((q ^ d) == {WIDTH{1'b1}})
        else $error("inverted operand mismatch");
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_fn_e          fn,
  input  logic             cin,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  function automatic logic [WIDTH-1:0] add_fn(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y,
                                              input logic c);
    return x + y + (c ? ONE : '0);
  endfunction

  always_comb begin
    unique case (fn)
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_NOTB: res = ~b;
      FN_ADD:  res = add_fn(a, b, cin);
      default: res = '0;
    endcase
  end

  always_comb begin
    if (fn == FN_ADD) begin
      assert_sum_inverts_R4: assert ((res - a - (cin ? ONE : '0)) == b)
        else $error("adder result inconsistent");
    end
    if (fn == FN_NOTB) begin
      assert_notb_ignores_a_R3: assert ((res ^ b) == {WIDTH{1'b1}})
        else $error("NOT B mismatch");
    end
  end

endmodule

// File: rtl/result_shifter.sv
module result_shifter
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int LSHIFT = 8,
  parameter int RSHIFT = 1
) (
  input  shift_ctl_t       sh,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_l;

  generate
    if (LSHIFT >= WIDTH) begin : g_lwide
      assign stage_l = sh.left ? '0 : d;
    end else begin : g_lnorm
      assign stage_l = sh.left ? (d << LSHIFT) : d;
    end
  endgenerate

  assign q = sh.right ? WIDTH'($signed(stage_l) >>> RSHIFT) : stage_l;

  always_comb begin
    if (!sh.left && !sh.right) begin
      assert_pass_through_R6: assert (q == d) else $error("no-shift altered data");
    end
    if (sh.left && !sh.right && LSHIFT < WIDTH) begin
      assert_left_zero_fill_R7: assert ((q & ~({WIDTH{1'b1}} << LSHIFT)) == '0)
        else $error("left shift low bits not zero");
    end
    if (sh.right) begin
      assert_sign_kept_R8: assert (q[WIDTH-1] == stage_l[WIDTH-1])
        else $error("arithmetic shift lost sign");
    end
  end

endmodule

// File: rtl/datapath_alu.sv
module datapath_alu
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int LSHIFT = 8,
  parameter int RSHIFT = 1
) (
  input  logic [5:0]       fn_ctl,
  input  logic [1:0]       sh_ctl,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] c_out,
  output logic             neg_flag,
  output logic             zero_flag
);

  alu_ctl_t         ctl;
  shift_ctl_t       shc;
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] alu_res;

  assign ctl = alu_ctl_t'(fn_ctl);
  assign shc = shift_ctl_t'(sh_ctl);

  operand_gate #(.WIDTH(WIDTH)) u_gate_a (
    .en(ctl.en_a), .inv(ctl.inv_a), .d(a_in), .q(a_eff)
  );

  operand_gate #(.WIDTH(WIDTH)) u_gate_b (
    .en(ctl.en_b), .inv(1'b0), .d(b_in), .q(b_eff)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .fn(ctl.fn), .cin(ctl.cin), .a(a_eff), .b(b_eff), .res(alu_res)
  );

  result_shifter #(.WIDTH(WIDTH), .LSHIFT(LSHIFT), .RSHIFT(RSHIFT)) u_shift (
    .sh(shc), .d(alu_res), .q(c_out)
  );

  assign neg_flag  = alu_res[WIDTH-1];
  assign zero_flag = (alu_res == '0);

  always_comb begin
    assert_flags_exclusive_R10: assert (!(neg_flag && zero_flag))
      else $error("sign and zero both set");
    if (zero_flag) begin
      assert_zero_shifts_zero_R11: assert (c_out == '0)
        else $error("zero result shifted to nonzero");
    end
  end

endmodule

// File: tb/datapath_alu_tb.sv
module datapath_alu_tb;

  logic        clk = 1'b0;
  logic [5:0]  fn_ctl = '0;
  logic [1:0]  sh_ctl = '0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [31:0] c_out;
  logic        neg_flag, zero_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  datapath_alu u_dut (
    .fn_ctl(fn_ctl), .sh_ctl(sh_ctl), .a_in(a_in), .b_in(b_in),
    .c_out(c_out), .neg_flag(neg_flag), .zero_flag(zero_flag)
  );

  // Behavioural model written from the requirements.
  function automatic void model(input logic [5:0] f, input logic [1:0] s,
                                input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] c, output logic n, output logic z);
    longint unsigned la, lb, sum;
    logic [31:0] x, y, r;
    longint signed sv;
    la = f[3] ? longint'(a) : 0;
    if (f[1]) la = la ^ 64'hFFFF_FFFF;
    lb = f[2] ? longint'(b) : 0;
    x = la[31:0];
    y = lb[31:0];
    case (f[5:4])
      2'd0: r = x & y;
      2'd1: r = x | y;
      2'd2: r = ~y;
      default: begin
        sum = la + lb + (f[0] ? 1 : 0);
        r = sum[31:0];
      end
    endcase
    n = r[31];
    z = (r == 0);
    c = r;
    if (s[1]) c = c << 8;
    if (s[0]) begin
      sv = longint'($signed(c));
      sv = sv / 2 - ((sv < 0 && sv % 2 != 0) ? 1 : 0);
      c = sv[31:0];
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h (fn=%06b sh=%02b a=%08h b=%08h)",
               tag, got, exp, fn_ctl, sh_ctl, a_in, b_in);
    end
  endtask

  task automatic apply(input string tag, input logic [5:0] f, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] ec;
    logic en, ez;
    @(posedge clk);
    fn_ctl = f; sh_ctl = s; a_in = a; b_in = b;
    model(f, s, a, b, ec, en, ez);
    @(negedge clk);
    check({tag, " c_out"}, c_out, ec);
    check("R10 neg_flag", {31'b0, neg_flag}, {31'b0, en});
    check("R11 zero_flag", {31'b0, zero_flag}, {31'b0, ez});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    @(negedge clk);
    // reset state: all inputs zero gives AND of zeros
    check("R3 reset c_out", c_out, 32'h0);
    check("R11 reset zero_flag", {31'b0, zero_flag}, 32'h1);

    apply("R5 A+B",            6'b111100, 2'b00, 32'h0000_1234, 32'h0000_0101);
    apply("R5 B-1",            6'b110110, 2'b00, 32'hDEAD_BEEF, 32'h0000_0010);
    apply("R5 B-1 from zero",  6'b110110, 2'b00, 32'h1234_5678, 32'h0);
    apply("R1 disabled A add", 6'b110100, 2'b00, 32'hFFFF_FFFF, 32'h0000_0007);
    apply("R1 both off const0",6'b110000, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R2 const -1",       6'b110010, 2'b00, 32'h5555_5555, 32'h0);
    apply("R2 B-A",            6'b111111, 2'b00, 32'h0000_0005, 32'h0000_0009);
    apply("R4 const 1",        6'b110001, 2'b00, 32'h0, 32'h0);
    apply("R4 wrap",           6'b111101, 2'b00, 32'hFFFF_FFFF, 32'h0);
    apply("R4 cin ignored AND",6'b001101, 2'b00, 32'hF0F0_F0F0, 32'hFF00_FF00);
    apply("R3 AND",            6'b001100, 2'b00, 32'hF0F0_F0F0, 32'hFF00_FF00);
    apply("R3 OR",             6'b011100, 2'b00, 32'hF0F0_0000, 32'h0000_0F0F);
    apply("R3 NOT B",          6'b101100, 2'b00, 32'h1234_5678, 32'h0F0F_0F0F);
    apply("R2 AND inverted A", 6'b001110, 2'b00, 32'hFFFF_0000, 32'h1234_5678);
    apply("R6 pass",           6'b011100, 2'b00, 32'h8000_0001, 32'h0);
    apply("R7 left 8",         6'b011100, 2'b10, 32'h8100_00FF, 32'h0);
    apply("R7 sign from left", 6'b011100, 2'b10, 32'h0080_0000, 32'h0);
    apply("R8 asr neg",        6'b011100, 2'b01, 32'h8000_0002, 32'h0);
    apply("R8 asr pos",        6'b011100, 2'b01, 32'h7FFF_FFFF, 32'h0);
    apply("R9 both shifts",    6'b011100, 2'b11, 32'h00C0_0001, 32'h0);
    apply("R11 zero pre-shift",6'b111100, 2'b10, 32'h0100_0000, 32'h0);
    apply("R10 neg pre-shift", 6'b011100, 2'b10, 32'h8000_0000, 32'h0);

    lf = 32'hACE1_2468;
    for (int i = 0; i < 256; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply("R3 sweep", 6'(i), 2'(i >> 6), lf, {lf[15:0], lf[31:16]} ^ 32'h3C3C_A5A5);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule